// File: doc/BRIEF.md
# Software-Locked Register Memory Controller

This block is a 256-byte register memory that is addressed by byte. Its host side is a plain synchronous port with one shared 8-bit address, an 8-bit write word, a write enable and a read enable. Most of the space is general storage. Two bytes near the top set two potentiometer wiper positions. One is a 256-step channel, called fine here. The other is a 100-step channel, called coarse here. The block registers these positions and drives them out as outputs.

Writes can be refused in two ways. A hardware protect pin refuses every write while it is high. There is also software protection by region. A configuration byte picks which of three address regions are guarded, and that guard applies only while a lock state is active. The host enters or leaves the lock state by writing a two-byte key pair. The second key byte is checked against the first key byte as it is currently stored. A refused write leaves every byte and wiper unchanged and raises an error flag for one cycle.

The block is used behind a serial front end. That front end turns bus transactions into single-cycle read and write strobes.

Top module: `regmem_guard`

## Requirements
- R1: After reset, every byte reads 00h, both wiper outputs are 0, wp_error is 0, rd_data is 0 and the lock state is cleared.
- R2: A read strobe returns the addressed byte on rd_data after the next clock edge, and rd_data holds its value while rd_en is low. A read and a write to the same address in the same cycle return the contents from before that write.
- R3: Addresses 00h to F7h store and return any byte written while no protection applies.
- R4: A write to F8h sets wiper_fine to the full written byte after the same clock edge, and wiper_fine changes on no other write.
- R5: A write to F9h ignores bit 7. If the remaining 7-bit value is above 63h, wiper_coarse goes to 63h; otherwise it takes that value. A read of F9h returns the stored byte with bit 7 cleared.
- R6: FAh keeps only bits 2:0, and a read returns the upper five bits as 0. Bit 0 guards 00h–7Fh, bit 1 guards 80h–F7h and bit 2 guards F8h–FFh.
- R7: Writing 25h to FCh while FBh holds 56h enters the lock state. While locked, a write to a region whose FAh bit is set is refused and leaves the byte unchanged. A second byte other than 25h does not lock.
- R8: Writing 36h to FCh while FBh holds 67h leaves the lock state, and FAh can then be written freely.
- R9: Writes to FBh and FCh are accepted in the lock state even when bit 2 of FAh is set.
- R10: While locked, a write to FAh is refused if bit 2 of FAh is set or if the write would change bits 1:0. Otherwise it is accepted.
- R11: While hw_wp is 1, every write, including writes to the wipers and the key bytes, is refused with wp_error and leaves all contents unchanged.
- R12: wp_error is 1 for exactly the cycle after a refused write, and 0 after an accepted write or a cycle with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte address, shared by reads and writes |
| wr_data | input | 8 | Write word |
| hw_wp | input | 1 | Hardware write protect; 1 refuses all writes |
| rd_data | output | 8 | Read word, valid after the edge that follows rd_en |
| wp_error | output | 1 | One-cycle flag for a refused write |
| wiper_fine | output | 8 | 256-step wiper position |
| wiper_coarse | output | 7 | 100-step wiper position, 0 to 63h |

## Verification
A read and a write can target the same byte in the same cycle. The bench drives both strobes together on one address, once on plain storage and once on the coarse wiper byte. It expects the earlier contents on rd_data, and the new contents on a following read. A second overlap happens when a key write meets an active lock with bit 2 of FAh set. The bench checks that the key byte is still accepted, that a neighbouring guarded byte in the same region is refused, and that the unlock then lets that byte change.

// File: rtl/regmem_pkg.sv
package regmem_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_FINE   = 8'hF8;
  localparam logic [ADDR_W-1:0] A_COARSE = 8'hF9;
  localparam logic [ADDR_W-1:0] A_CFG    = 8'hFA;
  localparam logic [ADDR_W-1:0] A_KEY_HI = 8'hFB;
  localparam logic [ADDR_W-1:0] A_KEY_LO = 8'hFC;

  localparam logic [ADDR_W-1:0] MID_BASE = 8'h80;
  localparam logic [ADDR_W-1:0] TOP_BASE = 8'hF8;

  localparam logic [DATA_W-1:0] LOCK_HI   = 8'h56;
  localparam logic [DATA_W-1:0] LOCK_LO   = 8'h25;
  localparam logic [DATA_W-1:0] UNLOCK_HI = 8'h67;
  localparam logic [DATA_W-1:0] UNLOCK_LO = 8'h36;

  localparam int N_REGION = 3;

  typedef enum logic [1:0] {
    RG_LOW = 2'd0,
    RG_MID = 2'd1,
    RG_TOP = 2'd2
  } region_e;

  function automatic region_e region_of(input logic [ADDR_W-1:0] a);
    if (a >= TOP_BASE)      return RG_TOP;
    else if (a >= MID_BASE) return RG_MID;
    else                    return RG_LOW;
  endfunction
endpackage

// File: rtl/regmem_store.sv
module regmem_store
  import regmem_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_word,
  output logic          rd_live
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] live_q;

  // Array without reset, read-first: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wr_data;
    if (rd_en) rd_word <= mem[addr];
  end

  // Written-since-reset bits give the all-zero reset image.
  always_ff @(posedge clk) begin
    if (rst) begin
      live_q  <= '0;
      rd_live <= 1'b0;
    end else begin
      if (wr_en) live_q[addr] <= 1'b1;
      if (rd_en) rd_live <= live_q[addr];
    end
  end

  p_live_clear_r1 : assert property (@(posedge clk) rst |=> !rd_live);
endmodule

// File: rtl/regmem_lockctl.sv
module regmem_lockctl
  import regmem_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  input  logic          hw_wp,
  output logic          wr_ok,
  output logic          wp_error
);
  logic                locked_q;
  logic [N_REGION-1:0] guard_q;
  logic [DW-1:0]       key_hi_q;
  logic                refuse;
  region_e             rgn;
  logic                is_key;

  assign rgn    = region_of(addr);
  assign is_key = (addr == A_KEY_HI) || (addr == A_KEY_LO);

  always_comb begin
    refuse = 1'b0;
    if (hw_wp)
      refuse = 1'b1;
    else if (is_key)
      refuse = 1'b0;
    else if (addr == A_CFG)
      refuse = locked_q && (guard_q[RG_TOP] || (wr_data[1:0] != guard_q[1:0]));
    else
      refuse = locked_q && guard_q[rgn];
  end

  assign wr_ok = wr_en && !refuse;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b0;
      guard_q  <= '0;
      key_hi_q <= '0;
      wp_error <= 1'b0;
    end else begin
      wp_error <= wr_en && refuse;
      if (wr_ok && addr == A_CFG)    guard_q  <= wr_data[N_REGION-1:0];
      if (wr_ok && addr == A_KEY_HI) key_hi_q <= wr_data;
      if (wr_ok && addr == A_KEY_LO) begin
        if (key_hi_q == LOCK_HI && wr_data == LOCK_LO)
          locked_q <= 1'b1;
        else if (key_hi_q == UNLOCK_HI && wr_data == UNLOCK_LO)
          locked_q <= 1'b0;
      end
    end
  end

  p_hw_refuse_r11 : assert property (@(posedge clk) disable iff (rst)
    (wr_en && hw_wp) |=> wp_error);
  p_no_write_no_err_r12 : assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !wp_error);
  p_lock_needs_key_r7 : assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == A_KEY_LO) |=> $stable(locked_q));
  p_cfg_frozen_r10 : assert property (@(posedge clk) disable iff (rst)
    (locked_q && guard_q[RG_TOP]) |=> $stable(guard_q));
  p_key_open_r9 : assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_key && !hw_wp) |=> !wp_error);
endmodule

// File: rtl/regmem_wiper.sv
module regmem_wiper
  import regmem_pkg::*;
#(
  parameter int AW         = ADDR_W,
  parameter int DW         = DATA_W,
  parameter int COARSE_MAX = 99
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  we,
  input  logic [AW-1:0]                         addr,
  input  logic [DW-1:0]                         wr_data,
  output logic [DW-1:0]                         wiper_fine,
  output logic [$clog2(COARSE_MAX+1)-1:0]       wiper_coarse
);
  localparam int CW = $clog2(COARSE_MAX + 1);
  localparam logic [DW-1:0] LOW_MASK = {1'b0, {(DW-1){1'b1}}};

  logic [DW-1:0] low_part;
  logic [CW-1:0] coarse_next;

  assign low_part    = wr_data & LOW_MASK;
  assign coarse_next = (low_part > DW'(COARSE_MAX)) ? CW'(COARSE_MAX) : CW'(low_part);

  always_ff @(posedge clk) begin
    if (rst) begin
      wiper_fine   <= '0;
      wiper_coarse <= '0;
    end else if (we) begin
      if (addr == A_FINE)   wiper_fine   <= wr_data;
      if (addr == A_COARSE) wiper_coarse <= coarse_next;
    end
  end

  p_coarse_cap_r5 : assert property (@(posedge clk) disable iff (rst)
    wiper_coarse <= CW'(COARSE_MAX));
  p_fine_hold_r4 : assert property (@(posedge clk) disable iff (rst)
    !(we && addr == A_FINE) |=> $stable(wiper_fine));
endmodule

// File: rtl/regmem_guard.sv
module regmem_guard
  import regmem_pkg::*;
#(
  parameter int COARSE_MAX = 99
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  wr_en,
  input  logic                                  rd_en,
  input  logic [ADDR_W-1:0]                     addr,
  input  logic [DATA_W-1:0]                     wr_data,
  input  logic                                  hw_wp,
  output logic [DATA_W-1:0]                     rd_data,
  output logic                                  wp_error,
  output logic [DATA_W-1:0]                     wiper_fine,
  output logic [$clog2(COARSE_MAX+1)-1:0]       wiper_coarse
);
  localparam logic [DATA_W-1:0] CFG_MASK = DATA_W'((1 << N_REGION) - 1);
  localparam logic [DATA_W-1:0] COARSE_MASK = {1'b0, {(DATA_W-1){1'b1}}};

  logic              wr_ok;
  logic [DATA_W-1:0] rd_word;
  logic              rd_live;
  logic [DATA_W-1:0] rd_mask_q;

  regmem_lockctl #(.AW(ADDR_W), .DW(DATA_W)) u_lock (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .hw_wp(hw_wp), .wr_ok(wr_ok), .wp_error(wp_error)
  );

  regmem_store #(.AW(ADDR_W), .DW(DATA_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_ok), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_word(rd_word), .rd_live(rd_live)
  );

  regmem_wiper #(.AW(ADDR_W), .DW(DATA_W), .COARSE_MAX(COARSE_MAX)) u_wiper (
    .clk(clk), .rst(rst), .we(wr_ok), .addr(addr), .wr_data(wr_data),
    .wiper_fine(wiper_fine), .wiper_coarse(wiper_coarse)
  );

  // Read-side field mask, captured with the read strobe.
  always_ff @(posedge clk) begin
    if (rst)
      rd_mask_q <= '0;
    else if (rd_en) begin
      if (addr == A_CFG)         rd_mask_q <= CFG_MASK;
      else if (addr == A_COARSE) rd_mask_q <= COARSE_MASK;
      else                       rd_mask_q <= '1;
    end
  end

  assign rd_data = rd_live ? (rd_word & rd_mask_q) : '0;

  p_rd_hold_r2 : assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
  p_reset_out_r1 : assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !wp_error && wiper_fine == '0 && wiper_coarse == '0));
endmodule

// File: tb/test_regmem_guard.sv
module test_regmem_guard;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, hw_wp = 1'b1;
  logic [7:0] addr = '0, wr_data = '0;
  logic [7:0] rd_data, wiper_fine;
  logic [6:0] wiper_coarse;
  logic       wp_error;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  regmem_guard i_regmem_guard (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .hw_wp(hw_wp), .rd_data(rd_data), .wp_error(wp_error),
    .wiper_fine(wiper_fine), .wiper_coarse(wiper_coarse)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, output logic err);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk); #1; err = wp_error; wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(posedge clk); #1; d = rd_data; rd_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 wp_error", wp_error, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 wiper_fine", wiper_fine, 0);
    chk("R1 wiper_coarse", wiper_coarse, 0);
    rd(8'h00, d); chk("R1 byte 00", d, 0);
    rd(8'hF9, d); chk("R1 byte F9", d, 0);
  endtask

  task automatic t_storage;
    logic [7:0] d; logic e;
    wr(8'h00, 8'hA5, e); chk("R3 err 00", e, 0);
    wr(8'h7F, 8'h3C, e);
    wr(8'hF7, 8'hC3, e);
    rd(8'h00, d); chk("R3 read 00", d, 8'hA5);
    rd(8'h7F, d); chk("R3 read 7F", d, 8'h3C);
    rd(8'hF7, d); chk("R3 read F7", d, 8'hC3);
    @(negedge clk); chk("R2 hold", rd_data, 8'hC3);
    // R2: same-cycle read and write
    @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; addr = 8'h00; wr_data = 8'h11;
    @(posedge clk); #1; wr_en = 1'b0; rd_en = 1'b0;
    chk("R2 collision old", rd_data, 8'hA5);
    rd(8'h00, d); chk("R2 collision new", d, 8'h11);
  endtask

  task automatic t_wiper;
    logic [7:0] d; logic e;
    wr(8'hF8, 8'hFF, e); chk("R4 fine FF", wiper_fine, 8'hFF);
    wr(8'h10, 8'h22, e); chk("R4 fine unchanged", wiper_fine, 8'hFF);
    wr(8'hF8, 8'h00, e); chk("R4 fine 00", wiper_fine, 0);
    wr(8'hF9, 8'h85, e); chk("R5 coarse bit7", wiper_coarse, 5);
    rd(8'hF9, d); chk("R5 read F9", d, 8'h05);
    wr(8'hF9, 8'h7F, e); chk("R5 coarse 7F", wiper_coarse, 8'h63);
    wr(8'hF9, 8'h64, e); chk("R5 coarse 64", wiper_coarse, 8'h63);
    wr(8'hF9, 8'h63, e); chk("R5 coarse 63", wiper_coarse, 8'h63);
    // R2: collision on the coarse byte returns old masked value
    @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; addr = 8'hF9; wr_data = 8'h01;
    @(posedge clk); #1; wr_en = 1'b0; rd_en = 1'b0;
    chk("R2 collision F9", rd_data, 8'h63);
    chk("R5 coarse 01", wiper_coarse, 1);
  endtask

  task automatic t_lock;
    logic [7:0] d; logic e;
    wr(8'hFA, 8'hFF, e); rd(8'hFA, d); chk("R6 cfg mask", d, 8'h07);
    wr(8'hFA, 8'h03, e);
    wr(8'hFB, 8'h56, e);
    wr(8'hFC, 8'h24, e);
    wr(8'h10, 8'h77, e); chk("R7 wrong key no lock", e, 0);
    wr(8'hFC, 8'h25, e); chk("R9 key accepted", e, 0);
    wr(8'h10, 8'h88, e); chk("R7 low refused", e, 1);
    @(posedge clk); #1; chk("R12 err pulse", wp_error, 0);
    rd(8'h10, d); chk("R7 low unchanged", d, 8'h77);
    wr(8'h90, 8'h44, e); chk("R7 mid refused", e, 1);
    wr(8'hF8, 8'h5A, e); chk("R7 top open", e, 0);
    chk("R7 fine set", wiper_fine, 8'h5A);
    wr(8'hFA, 8'h02, e); chk("R10 low bits refused", e, 1);
    rd(8'hFA, d); chk("R10 cfg kept", d, 8'h03);
    wr(8'hFA, 8'h07, e); chk("R10 top bit accepted", e, 0);
    wr(8'hF8, 8'h11, e); chk("R7 top refused", e, 1);
    chk("R7 fine kept", wiper_fine, 8'h5A);
    wr(8'hFA, 8'h03, e); chk("R10 cfg frozen", e, 1);
    wr(8'hFB, 8'h67, e); chk("R9 key hi locked", e, 0);
    wr(8'hF8, 8'h12, e); chk("R9 top still refused", e, 1);
    wr(8'hFC, 8'h36, e); chk("R9 key lo locked", e, 0);
    wr(8'hF8, 8'h12, e); chk("R8 top open", e, 0);
    wr(8'h10, 8'h99, e); chk("R8 low open", e, 0);
    chk("R12 clear after accept", e, 0);
    wr(8'hFA, 8'h00, e); rd(8'hFA, d); chk("R8 cfg free", d, 0);
    rd(8'h10, d); chk("R8 low written", d, 8'h99);
  endtask

  task automatic t_hwwp;
    logic [7:0] d; logic e;
    hw_wp = 1'b1;
    wr(8'h20, 8'h5E, e); chk("R11 refused", e, 1);
    wr(8'hF8, 8'hEE, e); chk("R11 fine refused", e, 1);
    chk("R11 fine kept", wiper_fine, 8'h12);
    wr(8'hFB, 8'h56, e); chk("R11 key refused", e, 1);
    rd(8'h20, d); chk("R11 byte kept", d, 0);
    hw_wp = 1'b0;
    wr(8'h20, 8'h5E, e); chk("R11 released", e, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; hw_wp = 1'b0;
    #1;
    t_reset();
    t_storage();
    t_wiper();
    t_lock();
    t_hwwp();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule